// File: doc/BRIEF.md
# Indirect register-file addressing unit

This block is the address front end of a byte-wide register file. The core presents a direct address, a bank-select bit and read or write strobes. A pointer register is mapped at location 04h. Location 00h is a virtual window with no storage of its own. An access to 00h is redirected to the location whose address the pointer holds. Every other direct address passes straight through to the register file.

The unit forms a 9-bit effective address. Bit 8 comes from the bank-select bit and bits 7:0 come from either the direct address or the pointer. It drives read and write enables into a small RAM model that is held inside the block. A pointer that selects the virtual window is a self-reference. In that case a read returns zero and the write to storage is dropped. The flag-update permit stays asserted, so the status logic outside the block may still record the operation.

A parameter can remove the bank-select bit, which ties bit 8 of the effective address to zero.

Top module: `indir_addr_unit`

## Requirements
- R1: After reset the pointer holds 00h, so an indirect read made right after reset returns 00h.
- R2: A direct address other than 00h and 04h reaches RAM location {bank_sel, dir_addr}. A write there with wr_en is stored at the clock edge, and a later read with rd_en returns the stored byte.
- R3: When dir_addr is 00h and the pointer is not 00h, eff_addr is {bank_sel, pointer}, and reads and writes act on that location.
- R4: A read of 00h while the pointer holds 00h returns 00h and leaves ram_re low.
- R5: A write to 00h while the pointer holds 00h leaves ram_we low and changes no location, while flag_upd is still high. flag_upd is high for every write.
- R6: Address 04h, reached directly or through the pointer, reads and writes the pointer register. A pointer write is used by indirect accesses from the next cycle onward. No RAM enable is raised for it.
- R7: With BANK_EN = 0, eff_addr bit 8 is 0 whatever bank_sel is, and both bank settings reach the same location.
- R8: With 10h stored at 05h and 0Ah stored at 06h, pointer 05h makes an indirect read return 10h. After the pointer is raised to 06h, the same read returns 0Ah.
- R9: Clearing 20h..2Fh by writing 00h through the pointer, while stepping the pointer, zeroes exactly those locations and leaves every other location in bank 0 unchanged.
- R10: rd_data is 00h whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the pointer |
| dir_addr | input | 8 | Direct address from the core |
| bank_sel | input | 1 | Bank-select bit, becomes effective address bit 8 |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from the resolved location |
| eff_addr | output | 9 | Resolved effective address |
| ram_re | output | 1 | Read enable into the RAM model |
| ram_we | output | 1 | Write enable into the RAM model |
| flag_upd | output | 1 | Status flags may be updated for this write |

## Verification
The bench builds two copies that share their inputs. The main copy uses the default BANK_EN = 1, where bank 1 is a separate location space. This lets the bench show that bank 0 and bank 1 are kept apart for both direct and indirect accesses. The second copy uses BANK_EN = 0, which makes the folding of both banks onto one effective address observable, and it is checked against the same stimulus. Both copies use the default 8-bit address, with the virtual window at 00h and the pointer at 04h. This keeps the pointer-to-itself and pointer-to-pointer cases within reach of the clear loop and the directed tests.

// File: rtl/indir_addr_unit.sv
module indir_addr_unit #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter bit BANK_EN = 1'b1,
  parameter logic [ADDR_W-1:0] VIRT_ADDR = '0,
  parameter logic [ADDR_W-1:0] PTR_ADDR = ADDR_W'(4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic              bank_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W:0]   eff_addr,
  output logic              ram_re,
  output logic              ram_we,
  output logic              flag_upd
);

  localparam int EFF_W = ADDR_W + 1;
  localparam int DEPTH = 1 << EFF_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] ptr_q;
  logic              bank_bit;
  logic              is_virt;
  logic              self_ref;
  logic              hit_ptr;
  logic [ADDR_W-1:0] low_addr;

  generate
    if (BANK_EN) begin : g_bank
      assign bank_bit = bank_sel;
    end else begin : g_nobank
      assign bank_bit = 1'b0;
    end
  endgenerate

  assign is_virt  = dir_addr == VIRT_ADDR;
  assign low_addr = is_virt ? ptr_q : dir_addr;
  assign self_ref = is_virt && (ptr_q == VIRT_ADDR);
  assign hit_ptr  = low_addr == PTR_ADDR;
  assign eff_addr = {bank_bit, low_addr};

  assign ram_re   = rd_en && !self_ref && !hit_ptr;
  assign ram_we   = wr_en && !self_ref && !hit_ptr;
  assign flag_upd = wr_en;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (hit_ptr)     rd_data = DATA_W'(ptr_q);
      else if (ram_re) rd_data = mem[eff_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ptr_q <= '0;
    else if (wr_en && hit_ptr) ptr_q <= ADDR_W'(wr_data);
  end

  always_ff @(posedge clk) begin
    if (ram_we) mem[eff_addr] <= wr_data;
  end

  // R6
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dir_addr == PTR_ADDR) |=> ptr_q == ADDR_W'($past(wr_data)));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && eff_addr[ADDR_W-1:0] == PTR_ADDR) |=> $stable(ptr_q));

  // R2
  ram_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> mem[$past(eff_addr)] == $past(wr_data));

  // R3
  indir_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_addr == VIRT_ADDR && ptr_q != VIRT_ADDR) |-> eff_addr[ADDR_W-1:0] == ptr_q);

  // R4
  self_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && dir_addr == VIRT_ADDR && ptr_q == VIRT_ADDR) |-> (rd_data == '0 && !ram_re));

  // R5
  self_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dir_addr == VIRT_ADDR && ptr_q == VIRT_ADDR) |-> (!ram_we && flag_upd));

  // R7
  bank_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (BANK_EN == 1'b0 && bank_sel) |-> !eff_addr[ADDR_W]);

  // R10
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0 && !ram_re));

endmodule

// File: tb/indir_addr_unit_bench.sv
module indir_addr_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dir_addr = '0;
  logic       bank_sel = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, rd_nb;
  logic [8:0] eff_addr, eff_nb;
  logic       ram_re, ram_we, flag_upd;
  logic       re_nb, we_nb, fu_nb;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] got;

  always #2 clk = ~clk;

  indir_addr_unit u_indir_addr_unit (
    .clk(clk), .rst_n(rst_n), .dir_addr(dir_addr), .bank_sel(bank_sel),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .eff_addr(eff_addr), .ram_re(ram_re), .ram_we(ram_we), .flag_upd(flag_upd));

  indir_addr_unit #(.BANK_EN(1'b0)) u_indir_addr_unit_nb (
    .clk(clk), .rst_n(rst_n), .dir_addr(dir_addr), .bank_sel(bank_sel),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_nb),
    .eff_addr(eff_nb), .ram_re(re_nb), .ram_we(we_nb), .flag_upd(fu_nb));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic b, input logic [7:0] d);
    @(negedge clk);
    dir_addr = a; bank_sel = b; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic b, output logic [7:0] d);
    @(negedge clk);
    dir_addr = a; bank_sel = b; rd_en = 1'b1; wr_en = 1'b0;
    #1 d = rd_data;
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  // {is_read, bank, addr, data_or_expected}
  localparam logic [17:0] VEC [12] = '{
    {1'b0, 1'b0, 8'h05, 8'h10},
    {1'b0, 1'b0, 8'h06, 8'h0A},
    {1'b0, 1'b0, 8'h04, 8'h05},
    {1'b1, 1'b0, 8'h00, 8'h10},
    {1'b0, 1'b0, 8'h04, 8'h06},
    {1'b1, 1'b0, 8'h00, 8'h0A},
    {1'b1, 1'b0, 8'h04, 8'h06},
    {1'b0, 1'b1, 8'h05, 8'h33},
    {1'b1, 1'b1, 8'h05, 8'h33},
    {1'b1, 1'b0, 8'h05, 8'h10},
    {1'b0, 1'b1, 8'h00, 8'h77},
    {1'b1, 1'b1, 8'h06, 8'h77}
  };

  initial begin
    #4000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #9 rst_n = 1'b1;

    // R1 and R4: pointer is 0 after reset, so an indirect read gives zero
    rd(8'h00, 1'b0, got);
    chk(got == 8'h00, "R1", got, 0);
    @(negedge clk);
    dir_addr = 8'h00; rd_en = 1'b1;
    #1 chk(!ram_re, "R4", ram_re, 0);
    // R10: the read data is zero while no read is requested
    rd_en = 1'b0;
    #1 chk(rd_data == 8'h00, "R10", rd_data, 0);

    // R5: a self-referencing write stores nothing but still permits a flag update
    @(negedge clk);
    dir_addr = 8'h00; wr_data = 8'hAA; wr_en = 1'b1;
    #1 chk(!ram_we && flag_upd, "R5", {ram_we, flag_upd}, 1);
    @(posedge clk);
    #1 wr_en = 1'b0;
    rd(8'h00, 1'b0, got);
    chk(got == 8'h00, "R5", got, 0);

    // R8, R3, R6, R2: table walk (indirect example, banks, pointer readback)
    foreach (VEC[i]) begin
      if (VEC[i][17]) begin
        rd(VEC[i][15:8], VEC[i][16], got);
        chk(got == VEC[i][7:0], "R8", got, VEC[i][7:0]);
      end else begin
        wr(VEC[i][15:8], VEC[i][16], VEC[i][7:0]);
      end
    end

    // R3: indirect effective address carries the bank bit and the pointer
    @(negedge clk);
    dir_addr = 8'h00; bank_sel = 1'b1; rd_en = 1'b1;
    #1 chk(eff_addr == 9'h106, "R3", eff_addr, 9'h106);
    // R7: the copy without a bank bit drops bit 8
    chk(eff_nb == 9'h006, "R7", eff_nb, 9'h006);
    @(posedge clk);
    #1 rd_en = 1'b0;

    // R2: a direct address passes through unchanged
    @(negedge clk);
    dir_addr = 8'h9C; bank_sel = 1'b1; rd_en = 1'b1;
    #1 chk(eff_addr == 9'h19C, "R2", eff_addr, 9'h19C);
    chk(eff_nb == 9'h09C, "R7", eff_nb, 9'h09C);
    @(posedge clk);
    #1 rd_en = 1'b0;

    // R7: in the copy without a bank bit, a bank-1 write lands in the bank-0 location
    wr(8'h40, 1'b1, 8'hC3);
    @(negedge clk);
    dir_addr = 8'h40; bank_sel = 1'b0; rd_en = 1'b1;
    #1 chk(rd_nb == 8'hC3, "R7", rd_nb, 8'hC3);
    @(posedge clk);
    #1 rd_en = 1'b0;

    // R6: a pointer write is in use on the very next cycle, with no RAM enable
    wr(8'h41, 1'b0, 8'h5E);
    @(negedge clk);
    dir_addr = 8'h04; wr_data = 8'h41; wr_en = 1'b1; bank_sel = 1'b0;
    #1 chk(!ram_we, "R6", ram_we, 0);
    @(posedge clk);
    #1 wr_en = 1'b0;
    rd(8'h00, 1'b0, got);
    chk(got == 8'h5E, "R6", got, 8'h5E);
    // R6: an indirect write through pointer 04h reloads the pointer
    wr(8'h04, 1'b0, 8'h04);
    wr(8'h00, 1'b0, 8'h06);
    rd(8'h04, 1'b0, got);
    chk(got == 8'h06, "R6", got, 8'h06);

    // R9: fill bank 0, clear 20h..2Fh through the pointer, then compare
    for (int a = 1; a < 256; a++) begin
      if (a != 4) begin
        exp_mem[a] = 8'(a) ^ 8'h5A;
        wr(8'(a), 1'b0, exp_mem[a]);
      end
    end
    wr(8'h04, 1'b0, 8'h20);
    for (int n = 0; n < 16; n++) begin
      wr(8'h00, 1'b0, 8'h00);
      rd(8'h04, 1'b0, got);
      wr(8'h04, 1'b0, got + 8'h01);
    end
    for (int a = 8'h20; a < 8'h30; a++) exp_mem[a] = 8'h00;
    rd(8'h04, 1'b0, got);
    chk(got == 8'h30, "R9", got, 8'h30);
    for (int a = 1; a < 256; a++) begin
      if (a != 4) begin
        rd(8'(a), 1'b0, got);
        chk(got == exp_mem[a], "R9", got, exp_mem[a]);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule